// File: doc/BRIEF.md
# Supply Monitor Comparator Qualifier

This block sits between the analog comparators of a supply supervisor and the logic that acts on them. Each monitored rail has two raw comparator outputs, A and B, and a third ground-level comparator. The block first brings all of them into the core clock domain. It can then merge A and B into a single "inside the window" result. It can also replace B with the ground-level indication. Finally, it can deglitch each path with a tick-counted filter. This produces two qualified status bits per rail.

The qualified bits go straight to the power sequencing logic. A host can read the same bits as two status words: one word holds the A path bits and the other holds the B path bits. The deglitch counter runs on a prescaled tick. With the default 250 MHz clock, a prescale of 250 gives 1 microsecond ticks. A limit of 64 ticks then rejects glitches of up to 64 microseconds.

Top module: `smq_monitor_qual`

## Requirements
- R1: After reset, `qual_a`, `qual_b` and `rd_data` are all zero.
- R2: When the filter is off for a channel, a change on a raw input reaches its qualified output at the third rising clock edge after the change, and not earlier. This comes from two synchronizer stages plus one output register.
- R3: When `win_sel[i]` is 1, `qual_a[i]` carries the window result. The window result is 1 exactly when synchronized A is 1 and synchronized B is 0.
- R4: When `win_sel[i]` is 0, `qual_a[i]` carries synchronized A, whatever the value of B.
- R5: When `zd_sel[i]` is 1, the B path of channel i carries the inverse of the ground comparator `cmp_z_raw[i]`, so 1 means the rail is at ground. When `zd_sel[i]` is 0, the B path carries `cmp_b_raw[i]`.
- R6: When the filter is on, an input disagreement that lasts across at most FILT_LIMIT prescaler ticks leaves the output unchanged. A later disagreement starts counting from zero again.
- R7: When the filter is on, the output takes the new input level on the (FILT_LIMIT+1)th tick of continuous disagreement.
- R8: The filter behaves the same way for falling changes as for rising ones.
- R9: A read with `rd_en` high loads `rd_data` at the next clock edge from the status register. The status register holds the previous cycle's qualified bits, with channel i at bit i. `rd_sel`=0 selects the A path word and `rd_sel`=1 selects the B path word. While `rd_en` is low, `rd_data` holds its value.
- R10: Reads have no side effects. Repeated reads return the same word, and the qualified outputs do not change because of them.
- R11: Channels are independent. The configuration and inputs of one channel do not affect any other channel's outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_a_raw | input | NUM_CH | Raw A comparator per channel (asynchronous) |
| cmp_b_raw | input | NUM_CH | Raw B comparator per channel (asynchronous) |
| cmp_z_raw | input | NUM_CH | Raw ground-level comparator, 1 = rail above ground |
| win_sel | input | NUM_CH | 1 = A path carries window result |
| zd_sel | input | NUM_CH | 1 = B path carries at-ground indication |
| filt_en | input | NUM_CH | 1 = deglitch both paths of the channel |
| qual_a | output | NUM_CH | Qualified A path status |
| qual_b | output | NUM_CH | Qualified B path status |
| rd_en | input | 1 | Status read strobe |
| rd_sel | input | 1 | 0 = A path word, 1 = B path word |
| rd_data | output | NUM_CH | Registered status read data |

## Verification
The hardest case is the exact edge of the deglitch window. The filter counts free-running prescaler ticks whose phase cannot be seen at the ports, so a pulse length alone does not fix how many ticks it spans. To get around this, the bench uses a small prescale and a small limit. Rejected pulses last exactly FILT_LIMIT×PRESCALE cycles, which can never cover more than FILT_LIMIT ticks whatever the phase. Held levels are sampled both before the earliest possible flip and after the latest one. A second short pulse right after the first shows that the counter restarted.

// File: rtl/smq_pkg.sv
package smq_pkg;
  // Selects which qualified path the host read returns
  typedef enum logic {
    RD_WORD_A = 1'b0,
    RD_WORD_B = 1'b1
  } rd_word_e;
endpackage

// File: rtl/smq_tick_gen.sv
module smq_tick_gen #(
  parameter int PRESCALE = 250
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] pre_q, pre_d;

  always_comb begin
    pre_d = (pre_q == LAST) ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign tick = (pre_q == LAST);
endmodule

// File: rtl/smq_sync2.sv
module smq_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/smq_deglitch.sv
module smq_deglitch #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] CMAX = CW'(LIMIT);

  logic          out_q, out_d, out_ce;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_ce;
  logic          differ;

  always_comb begin
    differ = (din != out_q);
    out_d  = din;
    out_ce = 1'b0;
    cnt_d  = '0;
    cnt_ce = 1'b0;
    if (!en) begin
      out_ce = 1'b1;
      cnt_ce = (cnt_q != '0);
    end else if (!differ) begin
      cnt_ce = (cnt_q != '0);
    end else if (tick) begin
      cnt_ce = 1'b1;
      if (cnt_q == CMAX) begin
        out_ce = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (out_ce) out_q <= out_d;
      if (cnt_ce) cnt_q <= cnt_d;
    end
  end

  assign dout = out_q;
endmodule

// File: rtl/smq_monitor_qual.sv
module smq_monitor_qual #(
  parameter int NUM_CH     = 12,
  parameter int PRESCALE   = 250,
  parameter int FILT_LIMIT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] cmp_a_raw,
  input  logic [NUM_CH-1:0] cmp_b_raw,
  input  logic [NUM_CH-1:0] cmp_z_raw,
  input  logic [NUM_CH-1:0] win_sel,
  input  logic [NUM_CH-1:0] zd_sel,
  input  logic [NUM_CH-1:0] filt_en,
  output logic [NUM_CH-1:0] qual_a,
  output logic [NUM_CH-1:0] qual_b,
  input  logic              rd_en,
  input  logic              rd_sel,
  output logic [NUM_CH-1:0] rd_data
);
  import smq_pkg::*;

  logic              tick;
  logic [NUM_CH-1:0] path_a, path_b;
  logic [NUM_CH-1:0] qa, qb;
  logic [NUM_CH-1:0] stat_a_q, stat_b_q;
  logic [NUM_CH-1:0] rd_q, rd_d;

  smq_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [2:0] sync_q;
    logic       a_s, b_s, z_s;

    smq_sync2 #(.W(3)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({cmp_z_raw[ch], cmp_b_raw[ch], cmp_a_raw[ch]}),
      .q(sync_q)
    );

    assign a_s = sync_q[0];
    assign b_s = sync_q[1];
    assign z_s = sync_q[2];

    // window: above lower threshold (A) and not above upper (B)
    assign path_a[ch] = win_sel[ch] ? (a_s & ~b_s) : a_s;
    assign path_b[ch] = zd_sel[ch]  ? ~z_s        : b_s;

    smq_deglitch #(.LIMIT(FILT_LIMIT)) u_flt_a (
      .clk(clk), .rst_n(rst_n), .en(filt_en[ch]), .tick(tick),
      .din(path_a[ch]), .dout(qa[ch])
    );
    smq_deglitch #(.LIMIT(FILT_LIMIT)) u_flt_b (
      .clk(clk), .rst_n(rst_n), .en(filt_en[ch]), .tick(tick),
      .din(path_b[ch]), .dout(qb[ch])
    );
  end

  always_comb begin
    rd_d = (rd_word_e'(rd_sel) == RD_WORD_B) ? stat_b_q : stat_a_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_a_q <= '0;
      stat_b_q <= '0;
      rd_q     <= '0;
    end else begin
      stat_a_q <= qa;
      stat_b_q <= qb;
      if (rd_en) rd_q <= rd_d;
    end
  end

  assign qual_a  = qa;
  assign qual_b  = qb;
  assign rd_data = rd_q;
endmodule

// File: rtl/smq_monitor_qual_chk.sv
module smq_monitor_qual_chk #(
  parameter int NUM_CH = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] cmp_a_raw,
  input logic [NUM_CH-1:0] cmp_b_raw,
  input logic [NUM_CH-1:0] cmp_z_raw,
  input logic [NUM_CH-1:0] win_sel,
  input logic [NUM_CH-1:0] zd_sel,
  input logic [NUM_CH-1:0] filt_en,
  input logic [NUM_CH-1:0] qual_a,
  input logic [NUM_CH-1:0] qual_b,
  input logic              rd_en,
  input logic              rd_sel,
  input logic [NUM_CH-1:0] rd_data
);
  logic [2:0] cyc_q;
  logic       ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cyc_q <= '0;
    else if (cyc_q != 3'd4)   cyc_q <= cyc_q + 3'd1;
  end
  assign ready = (cyc_q == 3'd4);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    // R2 R4
    unfilt_direct_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !$past(filt_en[ch]) && !$past(win_sel[ch]))
      |-> (qual_a[ch] == $past(cmp_a_raw[ch], 3)));
    // R3
    unfilt_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !$past(filt_en[ch]) && $past(win_sel[ch]))
      |-> (qual_a[ch] == ($past(cmp_a_raw[ch], 3) & ~$past(cmp_b_raw[ch], 3))));
    // R5
    unfilt_b_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !$past(filt_en[ch]))
      |-> (qual_b[ch] == ($past(zd_sel[ch]) ? ~$past(cmp_z_raw[ch], 3)
                                             :  $past(cmp_b_raw[ch], 3))));
  end

  // R9
  read_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && rd_en) |=> (rd_data == ($past(rd_sel) ? $past(qual_b, 2) : $past(qual_a, 2))));
  // R9 R10
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !rd_en) |=> $stable(rd_data));
endmodule

bind smq_monitor_qual smq_monitor_qual_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmp_a_raw(cmp_a_raw), .cmp_b_raw(cmp_b_raw),
  .cmp_z_raw(cmp_z_raw), .win_sel(win_sel), .zd_sel(zd_sel), .filt_en(filt_en),
  .qual_a(qual_a), .qual_b(qual_b), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data)
);

// File: tb/smq_monitor_qual_tb_top.sv
`timescale 1ns/1ps
module smq_monitor_qual_tb_top;
  localparam int NCH = 12;
  localparam int PS  = 4;
  localparam int LIM = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] cmp_a, cmp_b, cmp_z, win_sel, zd_sel, filt_en, qual_a, qual_b, rd_data;
  logic rd_en, rd_sel;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  smq_monitor_qual #(.NUM_CH(NCH), .PRESCALE(PS), .FILT_LIMIT(LIM)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmp_a_raw(cmp_a), .cmp_b_raw(cmp_b), .cmp_z_raw(cmp_z),
    .win_sel(win_sel), .zd_sel(zd_sel), .filt_en(filt_en),
    .qual_a(qual_a), .qual_b(qual_b), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic sel, output logic [NCH-1:0] val);
    rd_en = 1'b1; rd_sel = sel;
    step(1);
    rd_en = 1'b0;
    val = rd_data;
  endtask

  task automatic t_reset();
    logic [NCH-1:0] v;
    check("R1 qual_a", qual_a, '0);
    check("R1 qual_b", qual_b, '0);
    check("R1 rd_data", rd_data, '0);
    do_read(1'b0, v); check("R1 status A", v, '0);
    do_read(1'b1, v); check("R1 status B", v, '0);
  endtask

  task automatic t_passthru();
    cmp_a = 12'hA5C;
    step(2); check("R2 not before third edge", qual_a, '0);
    step(1); check("R2 A after three edges", qual_a, 12'hA5C);
    cmp_b = 12'h3F0;
    step(3); check("R2 B after three edges", qual_b, 12'h3F0);
    check("R4 A unaffected by B", qual_a, 12'hA5C);
  endtask

  task automatic t_window();
    cmp_a = 12'hF0F; cmp_b = 12'h0FF; win_sel = '1;
    step(3); check("R3 window all", qual_a, 12'hF00);
    win_sel = 12'h00F;
    step(3); check("R3 R4 R11 mixed select", qual_a, (12'hF00 & 12'h00F) | (12'hF0F & ~12'h00F));
    win_sel = '0;
    step(3); check("R4 direct A", qual_a, 12'hF0F);
  endtask

  task automatic t_zero();
    cmp_b = 12'hC03; cmp_z = 12'h0A0; zd_sel = 12'h0FF;
    step(3); check("R5 R11 zero select", qual_b, (~12'h0A0 & 12'h0FF) | (12'hC03 & ~12'h0FF));
    zd_sel = '0;
    step(3); check("R5 raw B restored", qual_b, 12'hC03);
  endtask

  task automatic t_status();
    logic [NCH-1:0] v1, v2;
    step(2);
    do_read(1'b0, v1); check("R9 A word", v1, 12'hF0F);
    do_read(1'b0, v2); check("R10 repeat read", v2, v1);
    check("R10 qual_a after reads", qual_a, 12'hF0F);
    do_read(1'b1, v1); check("R9 B word", v1, 12'hC03);
    cmp_b = 12'h001;
    step(6); check("R9 hold without rd_en", rd_data, 12'hC03);
    do_read(1'b1, v1); check("R9 B word refreshed", v1, 12'h001);
  endtask

  task automatic t_filter();
    cmp_a = '0; cmp_b = '0; cmp_z = '0; win_sel = '0; zd_sel = '0; filt_en = '0;
    step(4);
    filt_en = 12'hFDF;                    // channel 5 stays unfiltered
    step(2);
    cmp_a[3] = 1'b1; step(LIM*PS); cmp_a[3] = 1'b0;
    step(50); check("R6 short rise rejected", qual_a, '0);
    cmp_a[3] = 1'b1; step(LIM*PS); cmp_a[3] = 1'b0;
    step(50); check("R6 counter restarts", qual_a, '0);
    cmp_a[3] = 1'b1; cmp_a[5] = 1'b1;
    step(3); check("R11 unfiltered ch5 direct", qual_a, 12'h020);
    step(LIM*PS - 1); check("R7 not before limit", qual_a, 12'h020);
    step(14); check("R7 held level passes", qual_a, 12'h028);
    cmp_a[3] = 1'b0; step(LIM*PS); cmp_a[3] = 1'b1;
    step(50); check("R8 short fall rejected", qual_a, 12'h028);
    cmp_a[3] = 1'b0;
    step(2 + LIM*PS); check("R8 fall not before limit", qual_a, 12'h028);
    step(14); check("R8 held fall passes", qual_a, 12'h020);
    check("R11 B paths untouched", qual_b, '0);
  endtask

  initial begin
    cmp_a = '0; cmp_b = '0; cmp_z = '0; win_sel = '0; zd_sel = '0; filt_en = '0;
    rd_en = 1'b0; rd_sel = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_passthru();
    t_window();
    t_zero();
    t_status();
    t_filter();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog: actual timeout expected completion");
        end
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule